// File: doc/BRIEF.md
# PLL Fast-Lock Mode Sequencer

This controller walks a phase detector and charge pump through three acquisition phases while a synthesizer loop settles after a retune. The loop starts in acquire, where frequency detection drives the loop with a deliberately modest current so that the VCO does not run past the closed-loop capture range. It then moves to a wide closed-loop phase, which uses a larger current to pull in quickly. It finishes in the final closed-loop phase, which uses the current chosen for the steady loop bandwidth. Each phase has its own programmed charge-pump current code. The code driven to the pump always matches the active phase.

The analog side stays outside the block and reports through digital flags. A frequency-closeness flag ends acquisition. An internal lock detector ends the wide phase; it counts consecutive valid phase comparisons that fall inside the lock window. If the wide-phase current is programmed as zero, the wide phase is skipped. A bypass input turns fast lock off and forces the final phase. A retune strobe restarts the sequence from acquire.

States: `FL_ACQ` (acquire), `FL_WIDE` (wide closed loop), `FL_FINAL` (final closed loop). Transitions: reset/retune → `FL_ACQ`; `FL_ACQ` → `FL_WIDE` on frequency-close with a nonzero wide code; `FL_ACQ` → `FL_FINAL` on frequency-close with a zero wide code, or on bypass; `FL_WIDE` → `FL_FINAL` on lock or on bypass; `FL_FINAL` holds.

Top module: `fastlock_seq`

## Requirements
- R1: A synchronous active-high `rst` puts the block in acquire and clears the lock count. `mode` is encoded 0 = acquire, 1 = wide closed loop, 2 = final closed loop, and never takes the value 3.
- R2: In acquire, with `freq_close` high, `retune` and `bypass` low and `cp_wide` nonzero, `mode` becomes 1 at the next clock edge. While `freq_close` stays low, acquire holds.
- R3: In acquire, with `freq_close` high, `retune` and `bypass` low and `cp_wide` equal to zero, `mode` goes directly to 2 at the next clock edge without ever showing 1.
- R4: In the wide phase, `mode` becomes 2 at the clock edge that captures the LOCK_N-th consecutive valid in-window sample (`smp_valid`=1, `smp_in_win`=1). With LOCK_N = 16, that is the 16th sample. Cycles with `smp_valid` low neither count nor break the run.
- R5: A valid sample with `smp_in_win` low clears the run of in-window samples, so LOCK_N further in-window samples are needed. The wide phase does not end on that cycle.
- R6: The final phase holds whatever `freq_close`, `smp_valid` and `smp_in_win` do, until `retune` or `rst`.
- R7: `retune` high at a clock edge returns `mode` to 0 from any state and clears the lock count. It takes priority over every other input except `rst`.
- R8: `cp_code` equals `cp_acq`, `cp_wide` or `cp_final` for mode 0, 1 or 2 respectively. It changes in the same cycle as `mode`, and it follows a changed code input without delay.
- R9: With `bypass` high and `retune` low, acquire and the wide phase both move to mode 2 at the next edge, and the final phase holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| retune | input | 1 | One-cycle strobe marking a new tuning event |
| bypass | input | 1 | Disables fast lock; run in final closed loop only |
| freq_close | input | 1 | Frequency detector reports inputs close enough to close the loop |
| smp_valid | input | 1 | A phase comparison result is present this cycle |
| smp_in_win | input | 1 | The present phase comparison is inside the lock window |
| cp_acq | input | CODE_W | Charge-pump code for acquire |
| cp_wide | input | CODE_W | Charge-pump code for wide closed loop (zero skips the phase) |
| cp_final | input | CODE_W | Charge-pump code for final closed loop |
| mode | output | 2 | Active phase: 0 acquire, 1 wide, 2 final |
| cp_code | output | CODE_W | Current code sent to the charge pump |

## Verification
A wrong state register shows on `mode` and `cp_code` in the very cycle after the faulty edge, because both are driven straight from it. A lock count that is off by one, or that survives a miss or a retune, stays hidden until the wide phase should end, and then shows as a final-phase entry one or more cycles early or late. For that reason the bench runs exact-length in-window runs, broken runs and runs interrupted by invalid cycles, and compares every cycle against a behavioural model that tracks the count as an integer.

// File: rtl/fastlock_pkg.sv
package fastlock_pkg;

    typedef enum logic [1:0] {
        FL_ACQ   = 2'd0,
        FL_WIDE  = 2'd1,
        FL_FINAL = 2'd2
    } fl_mode_t;

endpackage

// File: rtl/fl_lock_det.sv
module fl_lock_det #(
    parameter int LOCK_N = 16
) (
    input  logic clk,
    input  logic clear,
    input  logic smp_valid,
    input  logic smp_in_win,
    output logic lock_hit
);
    localparam int CNT_W = $clog2(LOCK_N + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(LOCK_N - 1);

    logic [CNT_W-1:0] run_q;

    // Lock is reported on the cycle that carries the final in-window sample.
    assign lock_hit = !clear && smp_valid && smp_in_win && (run_q == LAST);

    always_ff @(posedge clk) begin
        if (clear) begin
            run_q <= '0;
        end else if (smp_valid) begin
            if (!smp_in_win || run_q == LAST) begin
                run_q <= '0;
            end else begin
                run_q <= run_q + 1'b1;
            end
        end
    end

endmodule

// File: rtl/fl_mode_fsm.sv
module fl_mode_fsm
    import fastlock_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     retune,
    input  logic     bypass,
    input  logic     freq_close,
    input  logic     wide_zero,
    input  logic     lock_hit,
    output fl_mode_t state
);
    fl_mode_t state_q;
    fl_mode_t state_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= FL_ACQ;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        if (retune) begin
            state_d = FL_ACQ;
        end else begin
            unique case (state_q)
                FL_ACQ: begin
                    if (bypass) begin
                        state_d = FL_FINAL;
                    end else if (freq_close) begin
                        state_d = wide_zero ? FL_FINAL : FL_WIDE;
                    end
                end
                FL_WIDE: begin
                    if (bypass || lock_hit) begin
                        state_d = FL_FINAL;
                    end
                end
                FL_FINAL: state_d = FL_FINAL;
                default:  state_d = FL_ACQ;
            endcase
        end
    end

    assign state = state_q;

endmodule

// File: rtl/fl_code_sel.sv
module fl_code_sel
    import fastlock_pkg::*;
#(
    parameter int CODE_W = 4
) (
    input  fl_mode_t          state,
    input  logic [CODE_W-1:0] cp_acq,
    input  logic [CODE_W-1:0] cp_wide,
    input  logic [CODE_W-1:0] cp_final,
    output logic [CODE_W-1:0] cp_code
);
    always_comb begin
        unique case (state)
            FL_ACQ:   cp_code = cp_acq;
            FL_WIDE:  cp_code = cp_wide;
            FL_FINAL: cp_code = cp_final;
            default:  cp_code = '0;
        endcase
    end

endmodule

// File: rtl/fastlock_seq.sv
module fastlock_seq
    import fastlock_pkg::*;
#(
    parameter int CODE_W = 4,
    parameter int LOCK_N = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              retune,
    input  logic              bypass,
    input  logic              freq_close,
    input  logic              smp_valid,
    input  logic              smp_in_win,
    input  logic [CODE_W-1:0] cp_acq,
    input  logic [CODE_W-1:0] cp_wide,
    input  logic [CODE_W-1:0] cp_final,
    output logic [1:0]        mode,
    output logic [CODE_W-1:0] cp_code
);
    fl_mode_t state;
    logic     lock_hit;
    logic     lock_clear;
    logic     wide_zero;

    assign wide_zero  = (cp_wide == '0);
    assign lock_clear = rst || retune || (state != FL_WIDE);

    fl_lock_det #(.LOCK_N(LOCK_N)) u_lock (
        .clk        (clk),
        .clear      (lock_clear),
        .smp_valid  (smp_valid),
        .smp_in_win (smp_in_win),
        .lock_hit   (lock_hit)
    );

    fl_mode_fsm u_fsm (
        .clk        (clk),
        .rst        (rst),
        .retune     (retune),
        .bypass     (bypass),
        .freq_close (freq_close),
        .wide_zero  (wide_zero),
        .lock_hit   (lock_hit),
        .state      (state)
    );

    fl_code_sel #(.CODE_W(CODE_W)) u_sel (
        .state    (state),
        .cp_acq   (cp_acq),
        .cp_wide  (cp_wide),
        .cp_final (cp_final),
        .cp_code  (cp_code)
    );

    assign mode = state;

endmodule

// File: rtl/fastlock_seq_chk.sv
module fastlock_seq_chk #(
    parameter int CODE_W = 4
) (
    input logic              clk,
    input logic              rst,
    input logic              retune,
    input logic              bypass,
    input logic              freq_close,
    input logic              smp_valid,
    input logic              smp_in_win,
    input logic [CODE_W-1:0] cp_acq,
    input logic [CODE_W-1:0] cp_wide,
    input logic [CODE_W-1:0] cp_final,
    input logic [1:0]        mode,
    input logic [CODE_W-1:0] cp_code
);
    bit armed = 1'b0;
    always_ff @(posedge clk) begin
        if (rst) armed <= 1'b1;
    end

    // R1
    legal_mode_chk: assert property (@(posedge clk) disable iff (rst || !armed)
        mode != 2'd3);

    // R2
    acq_to_wide_chk: assert property (@(posedge clk) disable iff (rst || !armed)
        (mode == 2'd0 && !retune && !bypass && freq_close && cp_wide != '0) |=> mode == 2'd1);

    // R3
    skip_wide_chk: assert property (@(posedge clk) disable iff (rst || !armed)
        (mode == 2'd0 && !retune && !bypass && freq_close && cp_wide == '0) |=> mode == 2'd2);

    // R5
    miss_holds_wide_chk: assert property (@(posedge clk) disable iff (rst || !armed)
        (mode == 2'd1 && !retune && !bypass && smp_valid && !smp_in_win) |=> mode == 2'd1);

    // R6
    final_hold_chk: assert property (@(posedge clk) disable iff (rst || !armed)
        (mode == 2'd2 && !retune) |=> mode == 2'd2);

    // R7
    retune_restart_chk: assert property (@(posedge clk) disable iff (rst || !armed)
        retune |=> mode == 2'd0);

    // R8
    code_steady_chk: assert property (@(posedge clk) disable iff (rst || !armed)
        ($stable(mode) && $stable(cp_acq) && $stable(cp_wide) && $stable(cp_final)) |-> $stable(cp_code));

    // R9
    bypass_final_chk: assert property (@(posedge clk) disable iff (rst || !armed)
        (bypass && !retune) |=> mode == 2'd2);

endmodule

bind fastlock_seq fastlock_seq_chk #(.CODE_W(CODE_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .retune     (retune),
    .bypass     (bypass),
    .freq_close (freq_close),
    .smp_valid  (smp_valid),
    .smp_in_win (smp_in_win),
    .cp_acq     (cp_acq),
    .cp_wide    (cp_wide),
    .cp_final   (cp_final),
    .mode       (mode),
    .cp_code    (cp_code)
);

// File: tb/test_fastlock_seq.sv
module test_fastlock_seq;
    localparam int CODE_W = 4;
    localparam int LOCK_N = 16;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              retune = 1'b0;
    logic              bypass = 1'b0;
    logic              freq_close = 1'b0;
    logic              smp_valid = 1'b0;
    logic              smp_in_win = 1'b0;
    logic [CODE_W-1:0] cp_acq = 4'd3;
    logic [CODE_W-1:0] cp_wide = 4'd9;
    logic [CODE_W-1:0] cp_final = 4'd5;
    logic [1:0]        mode;
    logic [CODE_W-1:0] cp_code;

    int n_vec = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    fastlock_seq #(.CODE_W(CODE_W), .LOCK_N(LOCK_N)) i_fastlock_seq (
        .clk        (clk),
        .rst        (rst),
        .retune     (retune),
        .bypass     (bypass),
        .freq_close (freq_close),
        .smp_valid  (smp_valid),
        .smp_in_win (smp_in_win),
        .cp_acq     (cp_acq),
        .cp_wide    (cp_wide),
        .cp_final   (cp_final),
        .mode       (mode),
        .cp_code    (cp_code)
    );

    // Behavioural reference: phase number and length of the current in-window run.
    int ref_mode = 0;
    int ref_run  = 0;

    always @(posedge clk) begin
        if (rst || retune) begin
            ref_mode = 0;
            ref_run  = 0;
        end else if (ref_mode == 0) begin
            if (bypass) ref_mode = 2;
            else if (freq_close) ref_mode = (cp_wide == 0) ? 2 : 1;
            ref_run = 0;
        end else if (ref_mode == 1) begin
            if (bypass) begin
                ref_mode = 2;
                ref_run  = 0;
            end else if (smp_valid) begin
                if (!smp_in_win) ref_run = 0;
                else if (ref_run + 1 >= LOCK_N) begin
                    ref_mode = 2;
                    ref_run  = 0;
                end else ref_run = ref_run + 1;
            end
        end else begin
            ref_run = 0;
        end
    end

    function automatic int ref_code(input int m);
        if (m == 0) return int'(cp_acq);
        if (m == 1) return int'(cp_wide);
        return int'(cp_final);
    endfunction

    task automatic chk(input string tag, input int act, input int exp);
        n_vec++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    // Per-cycle comparison with the model, away from the active edge.
    always @(negedge clk) begin
        if (!rst && !done) begin
            chk("R1/R2-R7,R9 mode vs model", int'(mode), ref_mode);
            chk("R8 cp_code vs model", int'(cp_code), ref_code(ref_mode));
        end
    end

    task automatic tick();
        @(posedge clk);
        #2;
    endtask

    initial begin
        repeat (3) tick();
        chk("R1 reset mode", int'(mode), 0);
        chk("R1 reset code", int'(cp_code), 3);
        rst = 1'b0;

        repeat (4) tick();
        chk("R2 acquire holds without freq_close", int'(mode), 0);
        freq_close = 1'b1; tick(); freq_close = 1'b0;
        chk("R2 enter wide", int'(mode), 1);
        chk("R8 wide code", int'(cp_code), 9);

        smp_valid = 1'b1; smp_in_win = 1'b1;
        repeat (10) tick();
        smp_in_win = 1'b0; tick(); smp_in_win = 1'b1;
        chk("R5 miss keeps wide", int'(mode), 1);
        repeat (LOCK_N - 1) tick();
        chk("R5 run restarted after miss", int'(mode), 1);
        smp_valid = 1'b0; repeat (3) tick();
        chk("R4 invalid cycles hold", int'(mode), 1);
        smp_valid = 1'b1; tick();
        chk("R4 final on Nth sample", int'(mode), 2);
        chk("R8 final code", int'(cp_code), 5);

        freq_close = 1'b1; smp_in_win = 1'b0;
        repeat (5) tick();
        chk("R6 final holds", int'(mode), 2);
        freq_close = 1'b0;
        cp_final = 4'd12; #1;
        chk("R8 code follows input", int'(cp_code), 12);

        retune = 1'b1; tick(); retune = 1'b0;
        chk("R7 retune from final", int'(mode), 0);
        freq_close = 1'b1; tick(); freq_close = 1'b0;
        smp_in_win = 1'b1;
        repeat (10) tick();
        retune = 1'b1; tick(); retune = 1'b0;
        chk("R7 retune from wide", int'(mode), 0);
        freq_close = 1'b1; tick(); freq_close = 1'b0;
        repeat (10) tick();
        chk("R7 count cleared by retune", int'(mode), 1);
        repeat (LOCK_N - 10) tick();
        chk("R4 lock after fresh run", int'(mode), 2);
        smp_valid = 1'b0;

        cp_wide = 4'd0;
        retune = 1'b1; tick(); retune = 1'b0;
        freq_close = 1'b1; tick(); freq_close = 1'b0;
        chk("R3 zero wide code skips", int'(mode), 2);
        cp_wide = 4'd7;

        retune = 1'b1; tick(); retune = 1'b0;
        bypass = 1'b1; tick(); bypass = 1'b0;
        chk("R9 bypass from acquire", int'(mode), 2);
        retune = 1'b1; tick(); retune = 1'b0;
        freq_close = 1'b1; tick(); freq_close = 1'b0;
        chk("R2 wide before bypass", int'(mode), 1);
        bypass = 1'b1; tick(); bypass = 1'b0;
        chk("R9 bypass from wide", int'(mode), 2);

        for (int i = 0; i < 3000; i++) begin
            retune     = ($urandom_range(0, 59) == 0);
            bypass     = ($urandom_range(0, 99) == 0);
            freq_close = ($urandom_range(0, 7) == 0);
            smp_valid  = ($urandom_range(0, 3) != 0);
            smp_in_win = ($urandom_range(0, 29) != 0);
            if ($urandom_range(0, 199) == 0) cp_wide = 4'($urandom_range(0, 3));
            if ($urandom_range(0, 99) == 0) cp_final = 4'($urandom_range(0, 15));
            tick();
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        done = 1'b1;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule